// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between a clock synthesiser and the output pins of a clock generator. It stops the outputs cleanly on a power-down request and restarts them cleanly afterwards. The request pin counts only once it has been seen high at two consecutive rising edges of the reference clock. At that point every single-ended output is forced low at its own next falling edge. Each differential pair is parked at the next falling edge of its complement phase, in one of two park styles chosen by a per-group drive-mode bit. Once every output is parked, the block raises a shut-off signal for the oscillator and synthesiser.

Dropping the request acts at once, without waiting for a clock edge. The shut-off signal is withdrawn, and any true output that was left floating is driven high straight away. The outputs then stay parked until the lock flag from the synthesiser goes high. After lock, each output's enable is restored during that clock's own low phase, so the first pulse after restart is always full width.

All logic runs on one fast sampling clock. The source clocks arrive as level inputs that change away from its rising edge. The gating itself is an AND of the source with an enable that only changes while the source is low.

Top module: `clkout_pwrdn_seq`

## Requirements
- R1: After a synchronous active-low reset the status reads running (code 0), the oscillator shut-off output is low and every output is enabled.
- R2: A request that is high at only one rising edge of the reference input, or that drops low between two rising edges, does not start parking. A request seen high at two consecutive reference rising edges moves the status to parking (code 1).
- R3: While parking or parked, each single-ended output goes low at its source's next falling edge and stays low.
- R4: A differential group parks at the next falling edge of its complement source. With its drive-mode bit at 0, the parked true output is enabled and high, and the complement output enable is low.
- R5: With a group's drive-mode bit at 1, both the true and the complement output enables are low while parked and the request is still high.
- R6: Parking completes within 4 reference clock periods of qualification.
- R7: The shut-off output is high only in the parked-off status (code 2), and only after every output is parked.
- R8: When the request falls while outputs are parked, every differential true output is enabled and high in the same cycle, before any clock edge.
- R9: After release the status reads relocking (code 3) and every output stays parked until the lock input is high. The status then returns to running.
- R10: Every single-ended high pulse, including the first one after a restart, lasts exactly the source's full high phase; no runt pulse appears.
- R11: The status output uses the codes 0 running, 1 parking, 2 parked-off and 3 relocking, and follows the sequence running, parking, parked-off, relocking, running.
- R12: If the request falls while the status is parking, the status goes straight to relocking and then back to running once lock is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all sequencing logic |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | 1 | Power-down request; low releases at once |
| ref_t | input | 1 | Reference clock level used to qualify the request |
| pll_lock | input | 1 | Synthesiser lock indication |
| drv_mode | input | DIFF_COUNT | Per-group park style: 0 true high, 1 both floating |
| se_src | input | SE_COUNT | Single-ended source clock levels |
| dp_src_t | input | DIFF_COUNT | Differential true source levels |
| dp_src_c | input | DIFF_COUNT | Differential complement source levels |
| se_out | output | SE_COUNT | Gated single-ended outputs |
| dp_t_out | output | DIFF_COUNT | Differential true output levels |
| dp_t_oe | output | DIFF_COUNT | Differential true output enables |
| dp_c_out | output | DIFF_COUNT | Differential complement output levels |
| dp_c_oe | output | DIFF_COUNT | Differential complement output enables |
| osc_off | output | 1 | Permission to stop the oscillator and synthesiser |
| seq_state | output | 2 | Sequencer status code |

## Verification
The hardest case to reach is a release that lands in the middle of parking. Some outputs are parked by then and others are still running. The enables must come back only on low phases, with no runt pulse. The stimulus first waits until the status reads parking and drops the request on the very next sample. This catches the outputs that have the slowest sources before their falling edge. A second difficult case is a request that covers exactly one reference rising edge. The bench makes this with a pulse shorter than one reference period. It also holds the lock flag low well past release, to show that the parked state persists.

// File: rtl/clkout_pwrdn_pkg.sv
// Shared types for the clock output power-down sequencer.
// Assumes: status encoding is visible at the top-level port and must stay fixed.
package clkout_pwrdn_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN     = 2'd0,
        SEQ_PARKING = 2'd1,
        SEQ_OFF     = 2'd2,
        SEQ_RELOCK  = 2'd3
    } seq_state_t;

    localparam int DEFAULT_QUAL_EDGES = 2;

endpackage

// File: rtl/pd_req_qualifier.sv
// Qualifies the power-down request against rising edges of the reference
// clock level. The request counts once it has been high on QUAL_EDGES
// consecutive reference rising edges; any low sample clears the count at once.
// Assumes: ref_t and pd_req change away from the rising edge of clk.
module pd_req_qualifier #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic ref_t,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_EDGES + 1);
    localparam logic [CW-1:0] FULL = CW'(QUAL_EDGES);

    logic          ref_q;
    logic          ref_rise;
    logic [CW-1:0] edge_cnt;

    assign ref_rise = ref_t & ~ref_q;

    // Remember the reference level to find its rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_t;
    end

    // Count consecutive reference edges with the request high.
    always_ff @(posedge clk) begin
        if (!rst_n)                         edge_cnt <= '0;
        else if (!pd_req)                   edge_cnt <= '0;
        else if (ref_rise && edge_cnt != FULL) edge_cnt <= edge_cnt + 1'b1;
    end

    assign qualified = (edge_cnt == FULL);

endmodule

// File: rtl/se_clk_gate.sv
// Glitch-free gate for one single-ended clock. The enable drops only on a
// detected falling edge of the source, so the output is already low, and it
// rises only while the source is low, so the next high phase is complete.
// Assumes: src changes away from the rising edge of clk and has a low phase
// of at least one clk period.
module se_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic park_req,
    input  logic run_req,
    output logic gated,
    output logic enabled
);
    logic src_q;
    logic fall;

    assign fall = src_q & ~src;

    // Track the previous source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    // Drop the enable on a falling edge, restore it during the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                             enabled <= 1'b1;
        else if (park_req && enabled && fall)   enabled <= 1'b0;
        else if (run_req && !enabled && !src)   enabled <= 1'b1;
    end

    assign gated = src & enabled;

endmodule

// File: rtl/diff_clk_gate.sv
// Park and restart control for one differential output pair. The pair parks
// on the falling edge of the complement source, when the true source is high.
// Park style: mode 0 keeps the true pin driven high and floats the complement.
// Mode 1 floats both, until release drives the true pin high at once.
// Assumes: src_c is the inverse of src_t; both change away from clk rising edge.
module diff_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src_t,
    input  logic src_c,
    input  logic drv_mode,
    input  logic release_now,
    input  logic park_req,
    input  logic run_req,
    output logic t_out,
    output logic t_oe,
    output logic c_out,
    output logic c_oe,
    output logic enabled
);
    logic c_q;
    logic c_fall;
    logic hold_high;

    assign c_fall = c_q & ~src_c;

    // Track the previous complement level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= 1'b0;
        else        c_q <= src_c;
    end

    // Park on the complement's fall; restart during the true low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                               enabled <= 1'b1;
        else if (park_req && enabled && c_fall)   enabled <= 1'b0;
        else if (run_req && !enabled && !src_t)   enabled <= 1'b1;
    end

    // While parked, the true pin is held high for mode 0 or after release.
    assign hold_high = ~enabled & (~drv_mode | release_now);

    // Select running or parked pin levels and enables.
    always_comb begin
        if (enabled) begin
            t_out = src_t;
            t_oe  = 1'b1;
            c_out = src_c;
            c_oe  = 1'b1;
        end else begin
            t_out = 1'b1;
            t_oe  = hold_high;
            c_out = 1'b0;
            c_oe  = 1'b0;
        end
    end

endmodule

// File: rtl/pd_seq_fsm.sv
// Top-level sequence: running, parking, parked-off, relocking.
// Release (request low) leaves parking or parked-off on the next edge, and
// the pin-level effect of release is applied combinationally in the gates.
// Assumes: all_parked is the registered AND of every gate's parked state.
module pd_seq_fsm
    import clkout_pwrdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qualified,
    input  logic       pd_req,
    input  logic       all_parked,
    input  logic       pll_lock,
    output seq_state_t state,
    output logic       park_req,
    output logic       run_req,
    output logic       osc_off
);
    seq_state_t state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_RUN:     if (qualified)   state_nx = SEQ_PARKING;
            SEQ_PARKING: if (!pd_req)     state_nx = SEQ_RELOCK;
                         else if (all_parked) state_nx = SEQ_OFF;
            SEQ_OFF:     if (!pd_req)     state_nx = SEQ_RELOCK;
            SEQ_RELOCK:  if (pll_lock)    state_nx = SEQ_RUN;
            default:                      state_nx = SEQ_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_RUN;
        else        state <= state_nx;
    end

    assign park_req = (state == SEQ_PARKING) || (state == SEQ_OFF);
    assign run_req  = (state == SEQ_RUN);
    assign osc_off  = (state == SEQ_OFF);

endmodule

// File: rtl/clkout_pwrdn_seq.sv
// Clock output power-down sequencer top. Qualifies the request, parks each
// single-ended and differential output on its own clean edge, grants the
// oscillator shut-off once all are parked, and restarts after lock.
// Assumes: all source clocks are level inputs sampled by clk with at least
// one clk period per phase.
module clkout_pwrdn_seq
    import clkout_pwrdn_pkg::*;
#(
    parameter int SE_COUNT   = 4,
    parameter int DIFF_COUNT = 3,
    parameter int QUAL_EDGES = DEFAULT_QUAL_EDGES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_req,
    input  logic                  ref_t,
    input  logic                  pll_lock,
    input  logic [DIFF_COUNT-1:0] drv_mode,
    input  logic [SE_COUNT-1:0]   se_src,
    input  logic [DIFF_COUNT-1:0] dp_src_t,
    input  logic [DIFF_COUNT-1:0] dp_src_c,
    output logic [SE_COUNT-1:0]   se_out,
    output logic [DIFF_COUNT-1:0] dp_t_out,
    output logic [DIFF_COUNT-1:0] dp_t_oe,
    output logic [DIFF_COUNT-1:0] dp_c_out,
    output logic [DIFF_COUNT-1:0] dp_c_oe,
    output logic                  osc_off,
    output logic [1:0]            seq_state
);
    localparam int GATE_COUNT = SE_COUNT + DIFF_COUNT;

    logic                  qualified;
    logic                  park_req;
    logic                  run_req;
    logic                  all_parked;
    seq_state_t            state;
    logic [SE_COUNT-1:0]   se_en;
    logic [DIFF_COUNT-1:0] dp_en;
    logic [GATE_COUNT-1:0] gate_en;

    pd_req_qualifier #(
        .QUAL_EDGES (QUAL_EDGES)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .ref_t     (ref_t),
        .qualified (qualified)
    );

    pd_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .qualified  (qualified),
        .pd_req     (pd_req),
        .all_parked (all_parked),
        .pll_lock   (pll_lock),
        .state      (state),
        .park_req   (park_req),
        .run_req    (run_req),
        .osc_off    (osc_off)
    );

    for (genvar i = 0; i < SE_COUNT; i++) begin : g_se
        se_clk_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (se_src[i]),
            .park_req (park_req),
            .run_req  (run_req),
            .gated    (se_out[i]),
            .enabled  (se_en[i])
        );
    end

    for (genvar g = 0; g < DIFF_COUNT; g++) begin : g_dp
        diff_clk_gate u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_t       (dp_src_t[g]),
            .src_c       (dp_src_c[g]),
            .drv_mode    (drv_mode[g]),
            .release_now (~pd_req),
            .park_req    (park_req),
            .run_req     (run_req),
            .t_out       (dp_t_out[g]),
            .t_oe        (dp_t_oe[g]),
            .c_out       (dp_c_out[g]),
            .c_oe        (dp_c_oe[g]),
            .enabled     (dp_en[g])
        );
    end

    assign gate_en    = {dp_en, se_en};
    assign all_parked = ~|gate_en;
    assign seq_state  = state;

endmodule

// File: rtl/clkout_pwrdn_chk.sv
// Property checker for the power-down sequencer, bound to the top module.
// Assumes: status codes 0 run, 1 parking, 2 parked-off, 3 relocking.
module clkout_pwrdn_chk #(
    parameter int SE_COUNT       = 4,
    parameter int DIFF_COUNT     = 3,
    parameter int PARK_REF_LIMIT = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pd_req,
    input logic                  ref_t,
    input logic                  pll_lock,
    input logic [DIFF_COUNT-1:0] drv_mode,
    input logic [SE_COUNT-1:0]   se_out,
    input logic [DIFF_COUNT-1:0] dp_t_out,
    input logic [DIFF_COUNT-1:0] dp_t_oe,
    input logic [DIFF_COUNT-1:0] dp_c_oe,
    input logic                  osc_off,
    input logic [1:0]            seq_state
);
    logic       ref_q;
    logic [7:0] park_refs;

    // Count reference rising edges spent in the parking status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= 1'b0;
            park_refs <= '0;
        end else begin
            ref_q <= ref_t;
            if (seq_state != 2'd1)            park_refs <= '0;
            else if (ref_t && !ref_q && park_refs != 8'hFF) park_refs <= park_refs + 1'b1;
        end
    end

    assert_park_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        park_refs <= 8'(PARK_REF_LIMIT));

    assert_qualify_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd1 && $past(seq_state) == 2'd0) |-> $past(pd_req));

    assert_off_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |-> (se_out == '0 && dp_c_oe == '0 && seq_state == 2'd2));

    assert_se_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2) |-> (se_out == '0));

    assert_mode0_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2) |-> ((dp_t_oe & dp_t_out & ~drv_mode) == ~drv_mode));

    assert_mode1_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2 && pd_req) |-> ((dp_t_oe & drv_mode) == '0));

    assert_release_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2 && !pd_req) |-> (&(dp_t_oe & dp_t_out)));

    assert_relock_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd0 && $past(seq_state) == 2'd3) |-> $past(pll_lock));

    assert_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2) |-> ($past(seq_state) == 2'd1 || $past(seq_state) == 2'd2));

    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_state) == 2'd1 && !$past(pd_req)) |-> (seq_state == 2'd3));

endmodule

bind clkout_pwrdn_seq clkout_pwrdn_chk #(
    .SE_COUNT   (SE_COUNT),
    .DIFF_COUNT (DIFF_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .ref_t     (ref_t),
    .pll_lock  (pll_lock),
    .drv_mode  (drv_mode),
    .se_out    (se_out),
    .dp_t_out  (dp_t_out),
    .dp_t_oe   (dp_t_oe),
    .dp_c_oe   (dp_c_oe),
    .osc_off   (osc_off),
    .seq_state (seq_state)
);

// File: tb/sim_clkout_pwrdn_seq.sv
module sim_clkout_pwrdn_seq;
    localparam int NSE = 4;
    localparam int ND  = 3;
    localparam int REF_P = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0, pd_req = 1'b0, ref_t = 1'b0, pll_lock = 1'b1;
    logic [ND-1:0]  drv_mode = '0;
    logic [NSE-1:0] se_src = '0;
    logic [ND-1:0]  dp_src_t = '0, dp_src_c = '1;
    logic [NSE-1:0] se_out;
    logic [ND-1:0]  dp_t_out, dp_t_oe, dp_c_out, dp_c_oe;
    logic           osc_off;
    logic [1:0]     seq_state;

    clkout_pwrdn_seq #(.SE_COUNT(NSE), .DIFF_COUNT(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .ref_t(ref_t), .pll_lock(pll_lock),
        .drv_mode(drv_mode), .se_src(se_src), .dp_src_t(dp_src_t), .dp_src_c(dp_src_c),
        .se_out(se_out), .dp_t_out(dp_t_out), .dp_t_oe(dp_t_oe), .dp_c_out(dp_c_out),
        .dp_c_oe(dp_c_oe), .osc_off(osc_off), .seq_state(seq_state)
    );

    int checks = 0, fails = 0, t = 0, cyc = 0;
    bit run_src = 0;
    int hl[NSE];

    function automatic int se_per(int i);
        case (i) 0: return 4; 1: return 6; 2: return 10; default: return 16; endcase
    endfunction
    function automatic int dp_per(int g);
        case (g) 0: return 4; 1: return 6; default: return 8; endcase
    endfunction

    // Behavioural reference model, advanced on every rising clock edge.
    int m_state, m_cnt, old_st;
    bit m_refq, allp;
    bit m_en_se[NSE], m_q_se[NSE], m_en_d[ND], m_q_dc[ND];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_refq = 0;
            for (int i = 0; i < NSE; i++) begin m_en_se[i] = 1; m_q_se[i] = 0; end
            for (int g = 0; g < ND; g++)  begin m_en_d[g] = 1;  m_q_dc[g] = 0; end
        end else begin
            old_st = m_state;
            allp = 1;
            for (int i = 0; i < NSE; i++) if (m_en_se[i]) allp = 0;
            for (int g = 0; g < ND; g++)  if (m_en_d[g])  allp = 0;
            case (old_st)
                0: if (m_cnt >= 2) m_state = 1;
                1: if (!pd_req) m_state = 3; else if (allp) m_state = 2;
                2: if (!pd_req) m_state = 3;
                default: if (pll_lock) m_state = 0;
            endcase
            for (int i = 0; i < NSE; i++) begin
                if ((old_st == 1 || old_st == 2) && m_en_se[i] && m_q_se[i] && !se_src[i]) m_en_se[i] = 0;
                else if (old_st == 0 && !m_en_se[i] && !se_src[i]) m_en_se[i] = 1;
                m_q_se[i] = se_src[i];
            end
            for (int g = 0; g < ND; g++) begin
                if ((old_st == 1 || old_st == 2) && m_en_d[g] && m_q_dc[g] && !dp_src_c[g]) m_en_d[g] = 0;
                else if (old_st == 0 && !m_en_d[g] && !dp_src_t[g]) m_en_d[g] = 1;
                m_q_dc[g] = dp_src_c[g];
            end
            if (!pd_req) m_cnt = 0;
            else if (ref_t && !m_refq && m_cnt < 2) m_cnt = m_cnt + 1;
            m_refq = ref_t;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Compare every output against the model, and check pulse widths.
    task automatic compare();
        logic [NSE-1:0] e_se;
        logic [ND-1:0]  e_toe, e_tout, e_coe, e_cout;
        if (!rst_n) return;
        for (int i = 0; i < NSE; i++) e_se[i] = se_src[i] & m_en_se[i];
        for (int g = 0; g < ND; g++) begin
            e_toe[g]  = m_en_d[g] | ~drv_mode[g] | ~pd_req;
            e_tout[g] = m_en_d[g] ? dp_src_t[g] : 1'b1;
            e_coe[g]  = m_en_d[g];
            e_cout[g] = m_en_d[g] ? dp_src_c[g] : 1'b0;
        end
        chk(seq_state == 2'(m_state), "R11", "status", seq_state, m_state);
        chk(osc_off == (m_state == 2), "R7", "osc_off", osc_off, m_state == 2);
        chk(se_out == e_se, "R3", "se_out", se_out, e_se);
        chk(dp_t_oe == e_toe, "R5", "dp_t_oe", dp_t_oe, e_toe);
        chk((dp_t_out & e_toe) == (e_tout & e_toe), "R4", "dp_t_out", dp_t_out, e_tout);
        chk(dp_c_oe == e_coe && (dp_c_out & e_coe) == (e_cout & e_coe), "R4", "dp_c", dp_c_oe, e_coe);
        for (int i = 0; i < NSE; i++) begin
            if (se_out[i]) hl[i]++;
            else if (hl[i] > 0) begin
                chk(hl[i] == se_per(i) / 2, "R10", $sformatf("pulse width se%0d", i), hl[i], se_per(i) / 2);
                hl[i] = 0;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        if (run_src) t++;
        for (int i = 0; i < NSE; i++) se_src[i] = (t % se_per(i)) >= se_per(i) / 2;
        for (int g = 0; g < ND; g++) begin
            dp_src_t[g] = (t % dp_per(g)) >= dp_per(g) / 2;
            dp_src_c[g] = ~dp_src_t[g];
        end
        ref_t = (t % REF_P) >= REF_P / 2;
    endtask

    task automatic wait_state(int s, int maxc, output int n);
        n = 0;
        while (seq_state != 2'(s) && n < maxc) begin step(); n++; end
    endtask

    task automatic pd_cycle(logic [ND-1:0] mode);
        int n;
        drv_mode = mode;
        pd_req = 1'b1;
        wait_state(1, 40, n);
        chk(seq_state == 2'd1, "R2", "qualified to parking", seq_state, 1);
        wait_state(2, 60, n);
        chk(n <= 4 * REF_P, "R6", "parking cycles", n, 4 * REF_P);
        chk(seq_state == 2'd2 && osc_off, "R7", "parked-off", seq_state, 2);
        chk(se_out == '0, "R3", "se parked low", se_out, 0);
        chk(dp_t_oe == ~mode, "R5", "true enables by mode", dp_t_oe, ~mode);
        chk((dp_t_out & ~mode) == ~mode && dp_c_oe == '0, "R4", "mode0 true high", dp_t_out, ~mode);
        pll_lock = 1'b0;
        repeat (10) step();
        pd_req = 1'b0;
        #1;
        chk(dp_t_oe == '1 && dp_t_out == '1, "R8", "release drives true high", dp_t_oe, 7);
        step();
        chk(seq_state == 2'd3 && !osc_off, "R9", "relocking after release", seq_state, 3);
        repeat (30) step();
        chk(seq_state == 2'd3 && se_out == '0 && dp_c_oe == '0, "R9", "held parked without lock", seq_state, 3);
        pll_lock = 1'b1;
        wait_state(0, 10, n);
        chk(seq_state == 2'd0, "R9", "running after lock", seq_state, 0);
        repeat (40) step();
        chk(dp_c_oe == '1, "R10", "all restarted", dp_c_oe, 7);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    initial begin
        int n;
        for (int i = 0; i < NSE; i++) hl[i] = 0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk(seq_state == 2'd0 && !osc_off, "R1", "reset status", seq_state, 0);
        chk(dp_c_oe == '1 && dp_t_oe == '1, "R1", "reset enables", dp_c_oe, 7);
        run_src = 1;
        repeat (40) step();

        // R2: a short request covers at most one reference rising edge.
        pd_req = 1'b1;
        repeat (5) step();
        pd_req = 1'b0;
        repeat (20) step();
        chk(seq_state == 2'd0 && se_out != 4'hx, "R2", "single edge ignored", seq_state, 0);

        pd_cycle(3'b010);
        pd_cycle(3'b101);
        pd_cycle(3'b000);
        pd_cycle(3'b111);

        // R12: release in the middle of parking.
        drv_mode = 3'b010;
        pd_req = 1'b1;
        wait_state(1, 40, n);
        pd_req = 1'b0;
        step();
        chk(seq_state == 2'd3, "R12", "abort to relocking", seq_state, 3);
        wait_state(0, 10, n);
        chk(seq_state == 2'd0, "R12", "back to running", seq_state, 0);
        repeat (40) step();
        chk(dp_c_oe == '1, "R12", "all restarted after abort", dp_c_oe, 7);

        summary();
    end
endmodule